// File: doc/BRIEF.md
# Pixel Read-Modify-Write Engine

This block carries out single-pixel operations on a byte-wide video memory. It sits between a drawing command source and a memory arbiter. Each request names a byte address, a pixel index inside that byte and a colour depth. The engine can read the pixel into a 16-bit copy buffer, write the buffer back to another pixel, or write it with colour zero treated as transparent. The buffer can also be loaded directly from the request's data word, so that true-colour values can be drawn. Each write to a pixel smaller than a byte is a read-modify-write of the byte that holds it, so the neighbouring pixels keep their values.

Two counters report collisions. The read-collision counter notes that a paste landed on a pixel that was already nonzero. The write-collision counter notes that such a pixel was actually overwritten. Both counters stop at their maximum and are cleared by a dedicated request. The memory side uses a request/acknowledge pair that the memory may stretch for any number of cycles. The engine accepts a new request only when it is idle, so a caller can issue operations back to back by watching the ready output.

Top module: `pixel_writer`

## Requirements
- R1: During and after reset, req_ready is 1, mem_req is 0, copy_buf is 0 and both collision counters are 0.
- R2: req_ready is high only while idle, and a request is taken on a clock where req_valid and req_ready are both high. Operation codes are: 0 copy, 1 paste, 2 masked paste, 3 set-RGB, 4 clear counters. Codes 5 to 7 are taken and have no effect. req_ready stays low while any memory access of the current request is pending.
- R3: Depth codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 bits per pixel, and codes 5 to 7 also select 16. Below 8 bits, pixel index i occupies the field that starts at bit i*bpp of the byte at req_addr, counting from the least significant bit. Index bits beyond those a depth needs are ignored. A 16-bit pixel keeps its low byte at req_addr and its high byte at req_addr+1.
- R4: A copy reads the pixel's byte or bytes and loads the pixel value, zero-extended, into copy_buf. It makes no memory write.
- R5: Set-RGB loads req_data into copy_buf on the clock after acceptance, with no memory access.
- R6: A normal paste writes copy_buf, truncated to the depth, into the pixel field, including the value 0. Every other bit of the byte is preserved, and no other byte is written.
- R7: A masked paste whose truncated buffer value is 0 writes no memory and leaves the write-collision counter unchanged. A nonzero value is written as in R6.
- R8: On every paste, normal or masked, the read-collision counter rises by 1 if the destination pixel was nonzero beforehand.
- R9: The write-collision counter rises by 1 when a paste writes the pixel and the pixel's previous value was nonzero.
- R10: A clear request sets both counters to 0 on the next clock.
- R11: A counter at its maximum value stays there instead of wrapping.
- R12: mem_req, mem_we, mem_addr and mem_wdata are held stable until a clock with mem_ack high. Read data is taken on that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request is taken |
| req_op | input | 3 | Operation code (R2) |
| req_addr | input | ADDR_W | Byte address of the pixel |
| req_idx | input | 3 | Pixel index inside the byte |
| req_depth | input | 3 | Depth code (R3) |
| req_data | input | 16 | Value for set-RGB |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete this clock |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| copy_buf | output | 16 | Copy buffer |
| rd_hits | output | CNT_W | Read-collision counter |
| wr_hits | output | CNT_W | Write-collision counter |

## Verification
A wrong shift or mask in the field logic corrupts the neighbouring pixels of the destination byte. This appears in memory when the write completes, a few cycles after acceptance. A wrong zero test shows up in two ways: a write strobe on a transparent paste, or a counter that differs from the model at the next idle cycle. A lost or repeated byte step shows up as a wrong read or write count, or as a request that never returns to ready. Memory latency is randomised, so a step that ignores mem_ack shows as a wrong byte.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int BYTE_W = 8;
  localparam int PIX_W  = 16;

  localparam logic [2:0] OP_COPY       = 3'd0;
  localparam logic [2:0] OP_PASTE      = 3'd1;
  localparam logic [2:0] OP_PASTE_MASK = 3'd2;
  localparam logic [2:0] OP_SET_RGB    = 3'd3;
  localparam logic [2:0] OP_CLEAR      = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_WRITE
  } pw_state_e;
endpackage

// File: rtl/pw_field.sv
module pw_field
  import pw_pkg::*;
(
  input  logic [2:0]       depth,
  input  logic [2:0]       idx,
  input  logic [PIX_W-1:0] old_word,
  input  logic [PIX_W-1:0] src_pix,
  output logic [PIX_W-1:0] old_pix,
  output logic [PIX_W-1:0] put_pix,
  output logic [PIX_W-1:0] merged
);
  logic [BYTE_W-1:0] fmask;
  logic [2:0]        shift;
  logic              wide;
  logic [BYTE_W-1:0] pos_mask;
  logic [BYTE_W-1:0] old_field;
  logic [BYTE_W-1:0] put_field;

  // field width and bit position inside the low byte
  always_comb begin
    wide = (depth >= 3'd4);
    case (depth)
      3'd0:    begin fmask = 8'h01; shift = idx;                end
      3'd1:    begin fmask = 8'h03; shift = {idx[1:0], 1'b0};   end
      3'd2:    begin fmask = 8'h0F; shift = {idx[0], 2'b00};    end
      default: begin fmask = 8'hFF; shift = 3'd0;               end
    endcase
  end

  always_comb begin
    pos_mask  = fmask << shift;
    old_field = (old_word[BYTE_W-1:0] >> shift) & fmask;
    put_field = src_pix[BYTE_W-1:0] & fmask;
    if (wide) begin
      old_pix = old_word;
      put_pix = src_pix;
      merged  = src_pix;
    end else begin
      old_pix = {{(PIX_W-BYTE_W){1'b0}}, old_field};
      put_pix = {{(PIX_W-BYTE_W){1'b0}}, put_field};
      merged  = {{(PIX_W-BYTE_W){1'b0}},
                 (old_word[BYTE_W-1:0] & ~pos_mask) | (put_field << shift)};
    end
  end
endmodule

// File: rtl/pw_sat_cnt.sv
module pw_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      q <= '0;
    else if (inc && q != TOP)
      q <= q + 1'b1;
  end

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0);

  a_r11_saturate: assert property (@(posedge clk) disable iff (rst)
    (q == TOP && !clr) |=> q == TOP);

  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && q != TOP) |=> q == $past(q) + 1'b1);
endmodule

// File: rtl/pixel_writer.sv
module pixel_writer
  import pw_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_idx,
  input  logic [2:0]        req_depth,
  input  logic [15:0]       req_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic [15:0]       copy_buf,
  output logic [CNT_W-1:0]  rd_hits,
  output logic [CNT_W-1:0]  wr_hits
);
  localparam int NCNT = 2;

  pw_state_e         state;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        idx_q;
  logic [2:0]        depth_q;
  logic              byte_sel;
  logic [PIX_W-1:0]  old_q;
  logic [PIX_W-1:0]  new_q;

  logic              accept;
  logic              wide_q;
  logic              last_byte;
  logic              is_paste;
  logic              old_nz;
  logic              put_nz;
  logic              skip_wr;
  logic              clr_cnt;
  logic [PIX_W-1:0]  old_pix;
  logic [PIX_W-1:0]  put_pix;
  logic [PIX_W-1:0]  merged;
  logic [NCNT-1:0]   hit_inc;
  logic [CNT_W-1:0]  hit_q [NCNT];

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign wide_q    = (depth_q >= 3'd4);
  assign last_byte = (byte_sel == wide_q);
  assign is_paste  = (op_q == OP_PASTE) || (op_q == OP_PASTE_MASK);
  assign old_nz    = |old_pix;
  assign put_nz    = |put_pix;
  assign skip_wr   = (op_q == OP_PASTE_MASK) && !put_nz;
  assign clr_cnt   = accept && (req_op == OP_CLEAR);

  assign hit_inc[0] = (state == ST_CALC) && is_paste && old_nz;
  assign hit_inc[1] = (state == ST_CALC) && is_paste && !skip_wr && old_nz;

  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = addr_q + ADDR_W'(byte_sel);
  assign mem_wdata = byte_sel ? new_q[15:8] : new_q[7:0];

  pw_field u_field (
    .depth    (depth_q),
    .idx      (idx_q),
    .old_word (old_q),
    .src_pix  (copy_buf),
    .old_pix  (old_pix),
    .put_pix  (put_pix),
    .merged   (merged)
  );

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    pw_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (clr_cnt),
      .inc (hit_inc[g]),
      .q   (hit_q[g])
    );
  end

  assign rd_hits = hit_q[0];
  assign wr_hits = hit_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= '0;
      addr_q   <= '0;
      idx_q    <= '0;
      depth_q  <= '0;
      byte_sel <= 1'b0;
      old_q    <= '0;
      new_q    <= '0;
      copy_buf <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q     <= req_op;
            addr_q   <= req_addr;
            idx_q    <= req_idx;
            depth_q  <= req_depth;
            byte_sel <= 1'b0;
            old_q    <= '0;
            if (req_op == OP_SET_RGB)
              copy_buf <= req_data;
            if (req_op == OP_COPY || req_op == OP_PASTE || req_op == OP_PASTE_MASK)
              state <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            if (byte_sel) old_q[15:8] <= mem_rdata;
            else          old_q[7:0]  <= mem_rdata;
            if (last_byte) begin
              byte_sel <= 1'b0;
              state    <= ST_CALC;
            end else begin
              byte_sel <= 1'b1;
            end
          end
        end
        ST_CALC: begin
          if (op_q == OP_COPY) begin
            copy_buf <= old_pix;
            state    <= ST_IDLE;
          end else if (skip_wr) begin
            state <= ST_IDLE;
          end else begin
            new_q <= merged;
            state <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            if (last_byte) begin
              byte_sel <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              byte_sel <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  a_r7_transparent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CALC && op_q == OP_PASTE_MASK && !put_nz) |=> !mem_req);

  a_r4_copy_reads_only: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_COPY && mem_req) |-> !mem_we);

  a_r5_set_rgb: assert property (@(posedge clk) disable iff (rst)
    (accept && req_op == OP_SET_RGB) |=> copy_buf == $past(req_data));
endmodule

// File: tb/pixel_writer_bench.sv
module pixel_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int CW   = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_idx = '0;
  logic [2:0]    req_depth = '0;
  logic [15:0]   req_data = '0;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          mem_ack = 1'b0;
  logic [7:0]    mem_rdata = '0;
  logic [15:0]   copy_buf;
  logic [CW-1:0] rd_hits;
  logic [CW-1:0] wr_hits;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  int vectors = 0;
  int miscompares = 0;
  int rd_seen = 0;
  int wr_seen = 0;
  int wcnt = 0;
  int m_buf = 0;
  int m_rh = 0;
  int m_wh = 0;
  bit run_chk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_writer #(.ADDR_W(AW), .CNT_W(CW)) u_pixel_writer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_idx(req_idx),
    .req_depth(req_depth), .req_data(req_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .copy_buf(copy_buf),
    .rd_hits(rd_hits), .wr_hits(wr_hits)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory with random wait states (R12)
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wcnt == 0) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_seen++;
        end else begin
          mem_rdata = mem[mem_addr];
          rd_seen++;
        end
        wcnt = $urandom_range(0, 2);
      end else begin
        wcnt--;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (run_chk && !rst) begin
      check("R2 ready low while memory busy", int'(mem_req && req_ready), 0);
      if (req_ready) begin
        check("R4/R5 copy_buf", int'(copy_buf), m_buf);
        check("R8 rd_hits", int'(rd_hits), m_rh);
        check("R9 wr_hits", int'(wr_hits), m_wh);
      end
    end
  end

  task automatic model(int op, int a, int idx, int dep, int data,
                       output int exp_rd, output int exp_wr);
    int bpp, nb, sh, fm, old, pix, b;
    bpp = (dep >= 4) ? 16 : (1 << dep);
    nb  = (bpp == 16) ? 2 : 1;
    fm  = (bpp == 16) ? 16'hFFFF : ((1 << bpp) - 1);
    sh  = (bpp < 8) ? (idx % (8 / bpp)) * bpp : 0;
    exp_rd = 0;
    exp_wr = 0;
    if (bpp == 16) old = {exp_mem[(a + 1) % 256], exp_mem[a]};
    else           old = (int'(exp_mem[a]) >> sh) & fm;
    if (op == 0) begin
      exp_rd = nb;
      m_buf = old;
    end else if (op == 1 || op == 2) begin
      exp_rd = nb;
      pix = m_buf & fm;
      if (old != 0 && m_rh < CMAX) m_rh++;
      if (!(op == 2 && pix == 0)) begin
        exp_wr = nb;
        if (old != 0 && m_wh < CMAX) m_wh++;
        if (bpp == 16) begin
          exp_mem[a]           = pix[7:0];
          exp_mem[(a + 1) % 256] = pix[15:8];
        end else begin
          b = (int'(exp_mem[a]) & ~(fm << sh)) | (pix << sh);
          exp_mem[a] = b[7:0];
        end
      end
    end else if (op == 3) begin
      m_buf = data & 16'hFFFF;
    end else if (op == 4) begin
      m_rh = 0;
      m_wh = 0;
    end
  endtask

  task automatic do_op(int op, int a, int idx, int dep, int data, string tag);
    int exp_rd, exp_wr, guard, bad;
    while (!req_ready) @(negedge clk);
    rd_seen = 0;
    wr_seen = 0;
    req_op    = op[2:0];
    req_addr  = a[7:0];
    req_idx   = idx[2:0];
    req_depth = dep[2:0];
    req_data  = data[15:0];
    req_valid = 1'b1;
    @(posedge clk);
    model(op, a, idx, dep, data, exp_rd, exp_wr);
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!req_ready && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " R2 request completes"}, int'(req_ready), 1);
    check({tag, " R4 read count"}, rd_seen, exp_rd);
    check({tag, " R7 write count"}, wr_seen, exp_wr);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    check({tag, " R6 memory image"}, bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = (i % 5 == 0) ? 8'h00 : 8'((i * 29 + 7) & 255);
      exp_mem[i] = mem[i];
    end
    mem[8'h10] = 8'hB3; exp_mem[8'h10] = 8'hB3;
    mem[8'h11] = 8'h0C; exp_mem[8'h11] = 8'h0C;
    mem[8'h20] = 8'h5A; exp_mem[8'h20] = 8'h5A;
    mem[8'h30] = 8'hFF; exp_mem[8'h30] = 8'hFF;
    mem[8'h40] = 8'h66; exp_mem[8'h40] = 8'h66;

    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(req_ready), 1);
    check("R1 no mem_req in reset", int'(mem_req), 0);
    check("R1 copy_buf reset", int'(copy_buf), 0);
    check("R1 counters reset", int'(rd_hits) + int'(wr_hits), 0);
    rst = 1'b0;
    run_chk = 1'b1;
    @(negedge clk);

    do_op(3, 0, 0, 4, 16'hB7A5, "R5 set-rgb");
    check("R5 buffer value", int'(copy_buf), 16'hB7A5);

    do_op(0, 8'h10, 1, 2, 0, "R4 copy 4bpp idx1");
    check("R4 copied high nibble", int'(copy_buf), 16'h000B);

    do_op(4, 0, 0, 0, 0, "R10 clear");
    do_op(2, 8'h20, 1, 2, 0, "R7 masked paste nonzero");
    check("R9 byte after masked write", int'(mem[8'h20]), 8'hBA);
    check("R9 wr_hits after overwrite", int'(wr_hits), 1);

    do_op(0, 8'h11, 1, 2, 0, "R4 copy zero");
    do_op(2, 8'h20, 1, 2, 0, "R7 masked transparent");
    check("R7 byte kept", int'(mem[8'h20]), 8'hBA);
    check("R8 rd_hits after transparent", int'(rd_hits), 2);
    check("R7 wr_hits unchanged", int'(wr_hits), 1);

    do_op(1, 8'h20, 1, 2, 0, "R6 normal paste zero");
    check("R6 nibble cleared", int'(mem[8'h20]), 8'h0A);
    do_op(2, 8'h20, 1, 2, 0, "R8 masked over zero");
    check("R8 rd_hits unchanged over zero", int'(rd_hits), 3);

    do_op(3, 0, 0, 0, 16'h0000, "R5 load zero");
    do_op(1, 8'h30, 5, 0, 0, "R3 1bpp idx5");
    check("R3 single bit cleared", int'(mem[8'h30]), 8'hDF);
    do_op(1, 8'h30, 6, 1, 0, "R3 2bpp idx6 uses idx2");
    check("R3 2bpp field cleared", int'(mem[8'h30]), 8'hCF);

    do_op(3, 0, 0, 0, 16'hC3E1, "R5 true colour");
    do_op(1, 8'h50, 0, 6, 0, "R3 depth code 6 is 16-bit");
    check("R3 low byte", int'(mem[8'h50]), 8'hE1);
    check("R3 high byte", int'(mem[8'h51]), 8'hC3);
    do_op(3, 0, 0, 0, 0, "R5 reload");
    do_op(0, 8'h50, 0, 4, 0, "R4 copy 16-bit");
    check("R4 16-bit copy", int'(copy_buf), 16'hC3E1);

    do_op(6, 8'h40, 0, 3, 16'h1234, "R2 undefined op");

    do_op(4, 0, 0, 0, 0, "R10 clear before saturation");
    for (int k = 0; k < 9; k++) do_op(1, 8'h40, 0, 3, 0, "R11 repeated paste");
    check("R11 rd_hits saturated", int'(rd_hits), CMAX);
    check("R11 wr_hits saturated", int'(wr_hits), CMAX);
    do_op(4, 0, 0, 0, 0, "R10 clear after saturation");
    check("R10 counters cleared", int'(rd_hits) + int'(wr_hits), 0);

    for (int k = 0; k < 120; k++)
      do_op($urandom_range(0, 6), $urandom_range(0, 255), $urandom_range(0, 7),
            $urandom_range(0, 6), $urandom_range(0, 65535), "R12 random mix");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R2 run did not complete actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule